// File: doc/BRIEF.md
# Clock Error Trim Adjuster

This block turns a free-running 32 kHz clock-enable stream into a corrected one-second tick for a calendar counter. It divides the enable pulses by a prescaler and, once per adjustment interval, shortens or lengthens one second by a programmed number of enable cycles. The interval is either a short one (10 seconds by default) or a long one (60 seconds by default). Each adjustment moves the tick by up to 63 input cycles, so a slow or fast crystal can be trimmed. Software converts a parts-per-billion error into a cycle count and programs it here.

Two write ports load the state. One loads an 8-bit trim word: a magnitude in bits 5:0 and a direction code in bits 7:6. The other loads the automatic-adjust enable and the interval select. The interval select can only change while the direction code is zero, so software must clear the direction before it moves to a different interval. All pins are plain level or pulse controls, so there is no back-pressure. The block accepts a write in any cycle, and `sec_tick` is a one-cycle pulse that nothing can stall. The current register contents are brought out for readback.

Top module: `clk_err_trim`

## Requirements
- R1: After reset `adj_rdata` is 0, `auto_en_q` is 0, `short_sel_q` is 0 and `sec_tick` is low.
- R2: While `auto_en_q` is 0, every second lasts exactly PRESCALE `tick_en` pulses, whatever the trim word holds.
- R3: With direction code 1 (add, bits 7:6 = 01) and magnitude M (bits 5:0), the boundary second lasts PRESCALE−M enable pulses, so it ends early. Every other second lasts PRESCALE.
- R4: With direction code 2 (subtract, bits 7:6 = 10) and magnitude M, the boundary second lasts PRESCALE+M enable pulses, so it ends late. No second is ever shorter than PRESCALE−63 or longer than PRESCALE+63.
- R5: With `short_sel_q` = 1 the interval is SHORT_SECS seconds, and with 0 it is LONG_SECS seconds. The boundary second is the one whose end is the Nth tick counted from the last restart, and the second in progress at the restart counts as the first.
- R6: A `ctl_we` write updates `short_sel_q` only when the current direction code is 0. Otherwise the select keeps its value, while `auto_en_q` is still written.
- R7: Direction code 3 and a magnitude of 0 both leave every second at PRESCALE pulses.
- R8: A write that changes `auto_en_q` or `short_sel_q` restarts the interval count.
- R9: `sec_tick` is a single-cycle pulse, asserted in the cycle after the enable pulse that completes a second. It is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One pulse per 32 kHz input cycle |
| adj_we | input | 1 | Load trim word |
| adj_wdata | input | 8 | Trim word: [7:6] direction, [5:0] magnitude |
| ctl_we | input | 1 | Load enable and interval select |
| ctl_auto_en | input | 1 | Automatic adjustment enable value |
| ctl_short_sel | input | 1 | Interval select value: 1 short, 0 long |
| adj_rdata | output | 8 | Current trim word |
| auto_en_q | output | 1 | Current automatic adjustment enable |
| short_sel_q | output | 1 | Current interval select |
| sec_tick | output | 1 | Corrected one-second pulse |

## Verification
The bench builds the block with PRESCALE = 128, SHORT_SECS = 3 and LONG_SECS = 5. Several full intervals of both lengths then fit in a short run. With a prescale of 128, even the largest magnitude of 63 is still about half a second, so the bounds on the shortest and longest second are exercised. Second lengths are measured in enable pulses under a random enable pattern. They are checked against the expected sequence for directed cases and for random trim words, intervals and enable settings.

// File: rtl/clk_err_trim_pkg.sv
package clk_err_trim_pkg;

  localparam int MAG_W   = 6;
  localparam int MAG_MAX = (1 << MAG_W) - 1;

  // Direction code sits in the top two bits of the trim word.
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_ADD  = 2'd1,
    DIR_SUB  = 2'd2,
    DIR_RSVD = 2'd3
  } trim_dir_e;

  typedef struct packed {
    trim_dir_e        dir;
    logic [MAG_W-1:0] mag;
  } trim_word_t;

endpackage

// File: rtl/clk_err_trim_regs.sv
module clk_err_trim_regs
  import clk_err_trim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adj_we,
  input  logic [7:0] adj_wdata,
  input  logic       ctl_we,
  input  logic       ctl_auto_en,
  input  logic       ctl_short_sel,
  output trim_word_t word_q,
  output logic       en_q,
  output logic       sel_q,
  output logic       restart
);

  logic sel_unlocked;
  logic sel_next;

  // Interval select is frozen while any direction code is programmed.
  assign sel_unlocked = (word_q.dir == DIR_NONE);
  assign sel_next     = sel_unlocked ? ctl_short_sel : sel_q;
  assign restart      = ctl_we && ((ctl_auto_en != en_q) || (sel_next != sel_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '{dir: DIR_NONE, mag: '0};
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      if (adj_we) begin
        word_q <= trim_word_t'(adj_wdata);
      end
      if (ctl_we) begin
        en_q  <= ctl_auto_en;
        sel_q <= sel_next;
      end
    end
  end

endmodule

// File: rtl/clk_err_trim_interval.sv
module clk_err_trim_interval #(
  parameter int SHORT_SECS = 10,
  parameter int LONG_SECS  = 60,
  localparam int MAX_SECS  = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS,
  localparam int IDX_W     = (MAX_SECS > 2) ? $clog2(MAX_SECS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel,
  input  logic             restart,
  input  logic             sec_done,
  output logic             boundary,
  output logic [IDX_W-1:0] sec_idx
);

  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_SECS - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_SECS - 1);

  logic [IDX_W-1:0] last_idx;
  logic             at_last;

  assign last_idx = sel ? SHORT_LAST : LONG_LAST;
  assign at_last  = (sec_idx >= last_idx);
  assign boundary = en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_idx <= '0;
    end else if (!en || restart) begin
      sec_idx <= '0;
    end else if (sec_done) begin
      sec_idx <= at_last ? '0 : sec_idx + 1'b1;
    end
  end

endmodule

// File: rtl/clk_err_trim_prescaler.sv
module clk_err_trim_prescaler
  import clk_err_trim_pkg::*;
#(
  parameter int PRESCALE = 32768,
  localparam int CNT_W   = $clog2(PRESCALE + MAG_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       boundary,
  input  trim_word_t word,
  output logic       sec_done,
  output logic       sec_tick
);

  localparam logic [CNT_W-1:0] BASE_TERM = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] pcount;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] mag_ext;

  assign mag_ext = CNT_W'(word.mag);

  // Terminal count moves only during the boundary second.
  always_comb begin
    term = BASE_TERM;
    if (boundary) begin
      unique case (word.dir)
        DIR_ADD: term = BASE_TERM - mag_ext;
        DIR_SUB: term = BASE_TERM + mag_ext;
        default: term = BASE_TERM;
      endcase
    end
  end

  assign sec_done = tick_en && (pcount >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcount   <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_done;
      if (tick_en) begin
        pcount <= sec_done ? '0 : pcount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clk_err_trim.sv
module clk_err_trim
  import clk_err_trim_pkg::*;
#(
  parameter int PRESCALE   = 32768,
  parameter int SHORT_SECS = 10,
  parameter int LONG_SECS  = 60,
  localparam int MAX_SECS  = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS,
  localparam int IDX_W     = (MAX_SECS > 2) ? $clog2(MAX_SECS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       adj_we,
  input  logic [7:0] adj_wdata,
  input  logic       ctl_we,
  input  logic       ctl_auto_en,
  input  logic       ctl_short_sel,
  output logic [7:0] adj_rdata,
  output logic       auto_en_q,
  output logic       short_sel_q,
  output logic       sec_tick
);

  trim_word_t       word_q;
  logic             restart;
  logic             boundary;
  logic             sec_done;
  logic [IDX_W-1:0] sec_idx;

  clk_err_trim_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .adj_we        (adj_we),
    .adj_wdata     (adj_wdata),
    .ctl_we        (ctl_we),
    .ctl_auto_en   (ctl_auto_en),
    .ctl_short_sel (ctl_short_sel),
    .word_q        (word_q),
    .en_q          (auto_en_q),
    .sel_q         (short_sel_q),
    .restart       (restart)
  );

  clk_err_trim_interval #(
    .SHORT_SECS (SHORT_SECS),
    .LONG_SECS  (LONG_SECS)
  ) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (auto_en_q),
    .sel      (short_sel_q),
    .restart  (restart),
    .sec_done (sec_done),
    .boundary (boundary),
    .sec_idx  (sec_idx)
  );

  clk_err_trim_prescaler #(
    .PRESCALE (PRESCALE)
  ) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .boundary (boundary),
    .word     (word_q),
    .sec_done (sec_done),
    .sec_tick (sec_tick)
  );

  assign adj_rdata = word_q;

endmodule

// File: rtl/clk_err_trim_chk.sv
module clk_err_trim_chk #(
  parameter int PRESCALE = 32768,
  parameter int IDX_W    = 6,
  parameter int MAG_MAX  = 63,
  localparam int LEN_W   = $clog2(PRESCALE + MAG_MAX + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             ctl_we,
  input logic [7:0]       adj_rdata,
  input logic             auto_en_q,
  input logic             short_sel_q,
  input logic             sec_tick,
  input logic [IDX_W-1:0] sec_idx
);

  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(PRESCALE - MAG_MAX);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PRESCALE + MAG_MAX);

  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (sec_tick) begin
      run_len <= tick_en ? LEN_W'(1) : '0;
    end else if (tick_en) begin
      run_len <= run_len + 1'b1;
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  p_tick_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(tick_en));

  p_sel_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && adj_rdata[7:6] != 2'd0) |=> $stable(short_sel_q));

  p_idle_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en_q |-> (sec_idx == '0));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(auto_en_q) || !$stable(short_sel_q)) |-> (sec_idx == '0));

  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (run_len >= LEN_MIN && run_len <= LEN_MAX));

endmodule

bind clk_err_trim clk_err_trim_chk #(
  .PRESCALE (PRESCALE),
  .IDX_W    (IDX_W),
  .MAG_MAX  (clk_err_trim_pkg::MAG_MAX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .ctl_we      (ctl_we),
  .adj_rdata   (adj_rdata),
  .auto_en_q   (auto_en_q),
  .short_sel_q (short_sel_q),
  .sec_tick    (sec_tick),
  .sec_idx     (sec_idx)
);

// File: tb/clk_err_trim_bench.sv
`timescale 1ns/1ps
module clk_err_trim_bench;

  localparam int P     = 128;
  localparam int SHORT = 3;
  localparam int LONG  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       adj_we = 1'b0;
  logic [7:0] adj_wdata = 8'h00;
  logic       ctl_we = 1'b0;
  logic       ctl_auto_en = 1'b0;
  logic       ctl_short_sel = 1'b0;
  logic [7:0] adj_rdata;
  logic       auto_en_q;
  logic       short_sel_q;
  logic       sec_tick;

  int checks = 0;
  int fails  = 0;
  int lens[$];
  int te_cnt = 0;
  logic last_te = 1'b0;
  logic prev_tick = 1'b0;
  int doubles = 0;
  bit run_te = 1'b0;

  always #2 clk = ~clk;

  clk_err_trim #(.PRESCALE(P), .SHORT_SECS(SHORT), .LONG_SECS(LONG)) u_clk_err_trim (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .adj_we(adj_we), .adj_wdata(adj_wdata),
    .ctl_we(ctl_we), .ctl_auto_en(ctl_auto_en), .ctl_short_sel(ctl_short_sel),
    .adj_rdata(adj_rdata), .auto_en_q(auto_en_q), .short_sel_q(short_sel_q),
    .sec_tick(sec_tick)
  );

  // Random enable pattern, about three pulses in four cycles.
  always @(posedge clk) begin
    #1 tick_en = run_te && (($urandom % 4) != 0);
  end

  // Measure each second in enable pulses, terminal pulse included.
  always @(negedge clk) begin
    if (rst_n) begin
      te_cnt = te_cnt + int'(last_te);
      if (sec_tick) begin
        lens.push_back(te_cnt);
        te_cnt = 0;
      end
      if (sec_tick && prev_tick) doubles++;
      prev_tick = sec_tick;
      last_te = tick_en;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(int k, int dir, int mag, int sel, int en);
    int n = sel ? SHORT : LONG;
    if (en != 0 && (k % n) == 0) begin
      if (dir == 1) return P - mag;
      if (dir == 2) return P + mag;
    end
    return P;
  endfunction

  task automatic write_adj(int dir, int mag);
    @(posedge clk); #1;
    adj_we = 1'b1; adj_wdata = {2'(dir), 6'(mag)};
    @(posedge clk); #1;
    adj_we = 1'b0;
  endtask

  task automatic write_ctl(int en, int sel);
    @(posedge clk); #1;
    ctl_we = 1'b1; ctl_auto_en = 1'(en); ctl_short_sel = 1'(sel);
    @(posedge clk); #1;
    ctl_we = 1'b0;
  endtask

  task automatic wait_sync();
    int s = lens.size();
    while (lens.size() == s) @(negedge clk);
    lens.delete();
  endtask

  task automatic configure(int dir, int mag, int sel, int en);
    wait_sync();
    write_adj(0, 0);
    write_ctl(0, sel);
    write_adj(dir, mag);
    write_ctl(en, sel);
  endtask

  task automatic collect(string tag, int n, int dir, int mag, int sel, int en);
    while (lens.size() < n) @(negedge clk);
    for (int k = 1; k <= n; k++) check(tag, lens[k-1], exp_len(k, dir, mag, sel, en));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 adj_rdata", int'(adj_rdata), 0);
    check("R1 auto_en_q", int'(auto_en_q), 0);
    check("R1 short_sel_q", int'(short_sel_q), 0);
    check("R1 sec_tick", int'(sec_tick), 0);
    run_te = 1'b1;

    // Disabled: trim word has no effect.
    configure(1, 40, 0, 0);
    collect("R2 disabled", 2 * LONG, 1, 40, 0, 0);

    // Add and subtract on the long interval.
    configure(1, 7, 0, 1);
    collect("R3 add long", 2 * LONG, 1, 7, 0, 1);
    configure(2, 63, 0, 1);
    collect("R4 sub max long", 2 * LONG, 2, 63, 0, 1);
    configure(1, 63, 1, 1);
    collect("R4 add max short", 3 * SHORT, 1, 63, 1, 1);

    // Short interval and readback of accepted select.
    configure(2, 21, 1, 1);
    check("R6 select accepted", int'(short_sel_q), 1);
    collect("R5 sub short", 3 * SHORT, 2, 21, 1, 1);

    // Select write ignored while direction nonzero; no restart.
    configure(1, 9, 0, 1);
    write_ctl(1, 1);
    @(negedge clk);
    check("R6 select locked", int'(short_sel_q), 0);
    check("R6 enable still written", int'(auto_en_q), 1);
    collect("R6 interval unchanged", 2 * LONG, 1, 9, 0, 1);

    // Reserved code and zero magnitude.
    configure(3, 30, 0, 1);
    collect("R7 code3", 2 * LONG, 3, 30, 0, 1);
    configure(1, 0, 1, 1);
    collect("R7 mag0", 2 * SHORT, 1, 0, 1, 1);

    // Restart on select change mid-interval.
    configure(0, 0, 0, 1);
    wait_sync();
    wait_sync();
    write_ctl(1, 1);
    write_adj(1, 8);
    collect("R8 restart on select", 2 * SHORT, 1, 8, 1, 1);

    // Restart on enable toggle mid-interval.
    configure(2, 12, 0, 1);
    wait_sync();
    wait_sync();
    write_ctl(0, 0);
    write_ctl(1, 0);
    collect("R8 restart on enable", 2 * LONG, 2, 12, 0, 1);

    // Random trim words, intervals and enables.
    for (int i = 0; i < 8; i++) begin
      int d = int'($urandom % 4);
      int m = int'($urandom % 64);
      int s = int'($urandom % 2);
      int e = (($urandom % 5) != 0) ? 1 : 0;
      configure(d, m, s, e);
      collect($sformatf("R5 random case %0d", i), 2 * (s ? SHORT : LONG) + 1, d, m, s, e);
    end

    check("R9 no back-to-back tick", doubles, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule